// File: doc/BRIEF.md
# Polled UART Register Port

This block is the register-side half of a simple serial port that sends and receives 8N1 characters: one start bit, eight data bits least significant first, and one stop bit. A processor reaches it over a 32-bit bus with byte addresses and word-aligned registers. The port has three live registers. The data word carries the character in both directions and two handshake flags. The control word holds an interface-mode field, two handshake overrides and a sticky overrun flag. The baud word is stored and passed straight out to an external rate generator. That generator returns a strobe, `tick16`, at sixteen times the bit rate. All serial timing is counted in these strobes.

Software needs no interrupt or DMA. It polls the data word. When the "transmitter free" flag reads 1, a write with that flag bit set hands over a character. When the "byte waiting" flag reads 1, the character can be read, and writing 1 to that flag bit releases it. Each direction holds one character. The held byte is shifted straight out of its holding register, so a write that arrives while the transmitter is busy cannot touch the character on the wire.

The transmitter state machine has four states. TX_IDLE moves to TX_START when a byte is pending, sending is allowed and a strobe arrives. TX_START moves to TX_DATA after 16 strobes. TX_DATA moves to TX_STOP after eight bits of 16 strobes each. TX_STOP returns to TX_IDLE after 16 strobes and releases the holding stage. The receiver state machine also has four states. RX_IDLE moves to RX_START when it sees a low line on a strobe. RX_START returns to RX_IDLE if the line goes high again (a glitch). Otherwise it moves to RX_DATA after eight low strobes, which is mid-bit. RX_DATA samples every 16 strobes and moves to RX_STOP after eight samples. RX_STOP returns to RX_IDLE after 16 strobes and delivers the byte if the stop bit is high.

Top module: `uart_mmio_port`

## Requirements
- R1: After reset:
  - the data word reads 0x200 (bit 9 free = 1, bit 8 waiting = 0);
  - the control word reads 0;
  - `txd_o` is 1, `rx_room_o` is 1 and `baud_cfg_o` is 0.
- R2: Register offsets:
  - Offset 0x00 is the data word, 0x04 the control word and 0x08 the baud word.
  - The baud word holds all 32 bits, reads back and drives `baud_cfg_o`.
  - Offsets 0x0C and 0x10 read 0.
  - Writes at offsets 0x14 and above are ignored.
  - In the control word, bits 3:2 are the mode field, bit 7 is the transmit override and bit 8 is the receive override; all three read back as written.
- R3: A write to the data word with bit 9 set while the transmitter is free loads bits 7:0. Bit 9 then reads 0 from the next cycle. `txd_o` sends the frame: start bit low, data bits LSB first, stop bit high, each bit 16 strobes long.
- R4: A write with bit 9 set while the transmitter is busy is ignored. The character in flight is unchanged and no extra frame is sent.
- R5: Bit 9 returns to 1 only after the stop bit has finished, about 10 bit times (160 strobes) after the launching write.
- R6: When control bit 7 is 0, a pending character waits until `tx_clear_i` is 1. When control bit 7 is 1, `tx_clear_i` is ignored.
- R7: A received character appears in data bits 7:0 with bit 8 set. A write to the data word with bit 8 set clears bit 8.
- R8: If a character completes while bit 8 is still set, the old character is kept and control bit 12 (overrun) becomes 1. Control bit 12 stays 1 until a write to the control word with bit 12 set.
- R9: A low pulse on `rxd_i` that lasts fewer than 8 strobes does not start a reception.
- R10: `rx_room_o` is 1 when no character is waiting or when control bit 8 is set. Otherwise it is 0.
- R11: A write to the data word with bit 9 clear does not launch a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick16 | input | 1 | Strobe from the rate generator, 16 per bit |
| tx_clear_i | input | 1 | Peer ready to receive (transmit handshake line) |
| rx_room_o | output | 1 | Port can accept a character (receive handshake line) |
| txd_o | output | 1 | Serial output, idles high |
| rxd_i | input | 1 | Serial input, asynchronous |
| baud_cfg_o | output | 32 | Baud word passed to the rate generator |

## Verification
If the transmit holding stage is corrupted, the character the bench decodes from `txd_o` differs from the one it queued. The mismatch shows within one frame. A pending flag that is stuck or released early shows as bit 9 reading 1 too soon after a launch, or as a missing or extra frame. Receive-side faults show up on the next poll of the data word after a frame ends: a lost or overwritten byte, a bit 8 that does not clear, or an overrun bit that is set wrongly or clears by itself. A start detector that accepts glitches shows as a spurious byte-waiting flag a few hundred cycles later.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
    localparam int BYTE_W    = 8;
    localparam int OFS_DATA  = 'h00;
    localparam int OFS_CTRL  = 'h04;
    localparam int OFS_BAUD  = 'h08;
    localparam int WIN_BYTES = 'h14;
    localparam int DB_WAIT   = 8;
    localparam int DB_FREE   = 9;
    localparam int CB_MODE   = 2;
    localparam int CB_TXOVR  = 7;
    localparam int CB_RXOVR  = 8;
    localparam int CB_OVRUN  = 12;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_mmio_pkg::*;
#(
    parameter int SUB = 16,
    parameter int DW  = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          allow,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic          ready,
    output logic          txd
);
    localparam int CW = $clog2(SUB);
    localparam int IW = $clog2(DW);

    tx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [DW-1:0] hold_q;
    logic          pend_q;
    logic          done;
    logic          last;

    assign last  = tick && (cnt_q == CW'(SUB-1));
    assign ready = !pend_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        done    = 1'b0;
        if (tick) cnt_d = last ? '0 : cnt_q + 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                cnt_d = '0;
                if (pend_q && allow && tick) state_d = TX_START;
            end
            TX_START: if (last) begin
                state_d = TX_DATA;
                idx_d   = '0;
            end
            TX_DATA: if (last) begin
                if (idx_q == IW'(DW-1)) state_d = TX_STOP;
                else idx_d = idx_q + 1'b1;
            end
            TX_STOP: if (last) begin
                state_d = TX_IDLE;
                done    = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            if (load) begin
                pend_q <= 1'b1;
                hold_q <= din;
            end else if (done) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd <= 1'b1;
        else begin
            unique case (state_d)
                TX_IDLE:  txd <= 1'b1;
                TX_START: txd <= 1'b0;
                TX_DATA:  txd <= hold_q[idx_d];
                TX_STOP:  txd <= 1'b1;
            endcase
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(hold_q)); // R4
    AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(done)); // R5
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_mmio_pkg::*;
#(
    parameter int SUB = 16,
    parameter int DW  = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    output logic          valid,
    output logic [DW-1:0] dout
);
    localparam int CW = $clog2(SUB);
    localparam int IW = $clog2(DW);

    rx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [DW-1:0] sh_q, sh_d;
    logic          s1_q, s2_q;
    logic          last;
    logic          deliver;

    assign last = tick && (cnt_q == CW'(SUB-1));
    assign dout = sh_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        deliver = 1'b0;
        if (tick) cnt_d = last ? '0 : cnt_q + 1'b1;
        unique case (state_q)
            RX_IDLE: begin
                cnt_d = '0;
                if (tick && !s2_q) state_d = RX_START;
            end
            RX_START: if (tick) begin
                if (s2_q) state_d = RX_IDLE;
                else if (cnt_q == CW'(SUB/2-1)) begin
                    state_d = RX_DATA;
                    cnt_d   = '0;
                    idx_d   = '0;
                end
            end
            RX_DATA: if (last) begin
                sh_d = {s2_q, sh_q[DW-1:1]};
                if (idx_q == IW'(DW-1)) state_d = RX_STOP;
                else idx_d = idx_q + 1'b1;
            end
            RX_STOP: if (last) begin
                state_d = RX_IDLE;
                deliver = s2_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            s1_q    <= rxd;
            s2_q    <= s1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= deliver;
    end

    AST_VALID_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(state_q) == RX_STOP); // R7
endmodule

// File: rtl/uart_mmio_port.sv
module uart_mmio_port
    import uart_mmio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SUB    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick16,
    input  logic              tx_clear_i,
    output logic              rx_room_o,
    output logic              txd_o,
    input  logic              rxd_i,
    output logic [31:0]       baud_cfg_o
);
    logic              in_win, wr_any, wr_data, wr_ctrl, wr_baud;
    logic              launch, ack;
    logic              tx_ready, rx_valid, full_after;
    logic [BYTE_W-1:0] rx_new, rx_byte_q;
    logic              rx_full_q;
    logic [1:0]        mode_q;
    logic              txovr_q, rxovr_q, ovr_q;
    logic [31:0]       baud_q;

    assign in_win  = 32'(bus_addr) < WIN_BYTES;
    assign wr_any  = bus_sel && bus_wr && in_win;
    assign wr_data = wr_any && (32'(bus_addr) == OFS_DATA);
    assign wr_ctrl = wr_any && (32'(bus_addr) == OFS_CTRL);
    assign wr_baud = wr_any && (32'(bus_addr) == OFS_BAUD);
    assign launch  = wr_data && bus_wdata[DB_FREE] && tx_ready;
    assign ack     = wr_data && bus_wdata[DB_WAIT];
    assign full_after = rx_full_q && !ack;

    uart_tx_shift #(.SUB(SUB), .DW(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .allow(txovr_q || tx_clear_i), .load(launch),
        .din(bus_wdata[BYTE_W-1:0]), .ready(tx_ready), .txd(txd_o));

    uart_rx_shift #(.SUB(SUB), .DW(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd_i),
        .valid(rx_valid), .dout(rx_new));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full_q <= 1'b0;
            rx_byte_q <= '0;
            ovr_q     <= 1'b0;
            mode_q    <= '0;
            txovr_q   <= 1'b0;
            rxovr_q   <= 1'b0;
            baud_q    <= '0;
        end else begin
            rx_full_q <= full_after;
            if (rx_valid && !full_after) begin
                rx_full_q <= 1'b1;
                rx_byte_q <= rx_new;
            end
            if (wr_ctrl) begin
                mode_q  <= bus_wdata[CB_MODE +: 2];
                txovr_q <= bus_wdata[CB_TXOVR];
                rxovr_q <= bus_wdata[CB_RXOVR];
                if (bus_wdata[CB_OVRUN]) ovr_q <= 1'b0;
            end
            if (rx_valid && full_after) ovr_q <= 1'b1;
            if (wr_baud) baud_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (32'(bus_addr))
            OFS_DATA: begin
                bus_rdata[BYTE_W-1:0] = rx_byte_q;
                bus_rdata[DB_WAIT]    = rx_full_q;
                bus_rdata[DB_FREE]    = tx_ready;
            end
            OFS_CTRL: begin
                bus_rdata[CB_MODE +: 2] = mode_q;
                bus_rdata[CB_TXOVR]     = txovr_q;
                bus_rdata[CB_RXOVR]     = rxovr_q;
                bus_rdata[CB_OVRUN]     = ovr_q;
            end
            OFS_BAUD: bus_rdata = baud_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign rx_room_o  = rxovr_q || !rx_full_q;
    assign baud_cfg_o = baud_q;

    AST_FREE_DROPS_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> $past(launch)); // R3
    AST_RXBYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_q && !ack |=> $stable(rx_byte_q)); // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && !(wr_ctrl && bus_wdata[CB_OVRUN]) |=> ovr_q); // R8
    AST_WAIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full_q) |-> $past(rx_valid)); // R7
endmodule

// File: tb/uart_mmio_port_test.sv
module uart_mmio_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tick16 = 1'b0;
    logic        tx_clear_i = 1'b1;
    logic        rx_room_o, txd_o;
    logic        rxd_i = 1'b1;
    logic [31:0] baud_cfg_o;

    int n_chk = 0, n_fail = 0, frames = 0;
    logic [7:0] exp_q[$];

    uart_mmio_port uut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) tick16 <= rst_n ? !tick16 : 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send(logic [7:0] b);
        exp_q.push_back(b);
        wr(5'h00, 32'h200 | 32'(b));
    endtask

    task automatic wait_free(output int cyc);
        logic [31:0] d;
        cyc = 0;
        rd(5'h00, d);
        while (!d[9] && cyc < 3000) begin
            @(negedge clk); cyc++;
            rd(5'h00, d);
        end
    endtask

    task automatic rx_frame(logic [7:0] b);
        @(negedge clk);
        rxd_i = 1'b0; repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_i = b[i]; repeat (32) @(negedge clk);
        end
        rxd_i = 1'b1; repeat (40) @(negedge clk);
    endtask

    // scoreboard monitor: decode txd_o, compare with queued bytes
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && txd_o === 1'b0) begin
                repeat (15) @(negedge clk);
                chk("R3 start bit", 32'(txd_o), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (32) @(negedge clk);
                    got[i] = txd_o;
                end
                repeat (32) @(negedge clk);
                chk("R3 stop bit", 32'(txd_o), 1);
                frames++;
                if (exp_q.size() == 0) chk("R4 unexpected frame", 32'(got), 32'hFFFF_FFFF);
                else chk("R3 frame byte", 32'(got), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc, f0, lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rd(5'h00, d); chk("R1 data reset", d, 32'h200);
        rd(5'h04, d); chk("R1 ctrl reset", d, 0);
        chk("R1 txd idle", 32'(txd_o), 1);
        chk("R1 rx_room", 32'(rx_room_o), 1);
        chk("R1 baud out", baud_cfg_o, 0);
        // R2
        wr(5'h08, 32'h0ABC_1234);
        rd(5'h08, d); chk("R2 baud readback", d, 32'h0ABC_1234);
        chk("R2 baud out", baud_cfg_o, 32'h0ABC_1234);
        rd(5'h0C, d); chk("R2 hole 0x0C", d, 0);
        rd(5'h10, d); chk("R2 hole 0x10", d, 0);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h04, d); chk("R2 outside window", d, 0);
        wr(5'h04, 32'h188);
        rd(5'h04, d); chk("R2 ctrl fields", d, 32'h188);
        wr(5'h04, 32'h0);
        // R3 + R5
        send(8'hA5);
        rd(5'h00, d); chk("R3 free drops", 32'(d[9]), 0);
        wait_free(cyc);
        chk("R5 free after stop", 32'(cyc >= 316 && cyc <= 326), 1);
        // R4
        f0 = frames;
        send(8'hC3);
        wr(5'h00, 32'h23C);
        wait_free(cyc);
        repeat (400) @(negedge clk);
        chk("R4 single frame", 32'(frames - f0), 1);
        chk("R4 queue drained", 32'(exp_q.size()), 0);
        // R6
        tx_clear_i = 1'b0;
        f0 = frames; lows = 0;
        send(8'h3C);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!txd_o) lows++;
        end
        chk("R6 held by handshake", 32'(lows), 0);
        rd(5'h00, d); chk("R6 still busy", 32'(d[9]), 0);
        tx_clear_i = 1'b1;
        wait_free(cyc);
        repeat (20) @(negedge clk);
        chk("R6 released", 32'(frames - f0), 1);
        tx_clear_i = 1'b0;
        wr(5'h04, 32'h80);
        send(8'h5A);
        wait_free(cyc);
        repeat (20) @(negedge clk);
        chk("R6 override", 32'(frames - f0), 2);
        wr(5'h04, 32'h0);
        tx_clear_i = 1'b1;
        // R11
        f0 = frames;
        wr(5'h00, 32'h0FF);
        rd(5'h00, d); chk("R11 still free", 32'(d[9]), 1);
        repeat (400) @(negedge clk);
        chk("R11 no frame", 32'(frames - f0), 0);
        // R7
        rx_frame(8'h96);
        rd(5'h00, d); chk("R7 byte waiting", d, 32'h396);
        chk("R10 room low", 32'(rx_room_o), 0);
        wr(5'h00, 32'h100);
        rd(5'h00, d); chk("R7 ack clears", d & 32'h300, 32'h200);
        chk("R10 room back", 32'(rx_room_o), 1);
        // R8
        rx_frame(8'h11);
        rx_frame(8'h22);
        rd(5'h00, d); chk("R8 old byte kept", d, 32'h311);
        rd(5'h04, d); chk("R8 overrun set", 32'(d[12]), 1);
        wr(5'h04, 32'h0);
        rd(5'h04, d); chk("R8 overrun sticky", 32'(d[12]), 1);
        wr(5'h04, 32'h1000);
        rd(5'h04, d); chk("R8 overrun cleared", d, 0);
        wr(5'h00, 32'h100);
        rx_frame(8'h33);
        rd(5'h00, d); chk("R8 after ack", d, 32'h333);
        wr(5'h00, 32'h100);
        // R9
        @(negedge clk);
        rxd_i = 1'b0; repeat (4) @(negedge clk);
        rxd_i = 1'b1; repeat (400) @(negedge clk);
        rd(5'h00, d); chk("R9 glitch ignored", d & 32'h300, 32'h200);
        rx_frame(8'h7E);
        rd(5'h00, d); chk("R9 next byte ok", d, 32'h37E);
        // R10
        wr(5'h04, 32'h100);
        chk("R10 override room", 32'(rx_room_o), 1);
        wr(5'h04, 32'h0);
        chk("R10 full no room", 32'(rx_room_o), 0);
        wr(5'h00, 32'h100);
        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule